// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Array

A bank of independent down-counting timers that share one prescaler. Four timers are 8 bits wide. The last timer (index 4) is 12 bits wide. Each timer takes its count tick from a 16-way source selector. The selector can pick a binary division of the system clock, one of three coarse divisions that software can restart, or a rising edge on one of three external pins.

While a timer is enabled, every selected tick decrements it. When the count runs out, the timer reloads its programmed value and pulses its own interrupt for one cycle. The 12-bit timer is programmed through two byte-wide registers. While that timer is stopped, software can read its live count back through the same two registers.

The CPU side is a plain register port. It has a write strobe and a read strobe, a shared 4-bit address, byte write data and a registered byte of read data.

Top module: `tmr_array`

## Requirements
- R1: After reset, all enable bits are 0, every reload value and count is 0, no interrupt is raised, read data is 0, timers 0 to 3 select source code 2 and timer 4 selects source code 9.
- R2: Source codes 0 to 9 give one tick every 2^code cycles, taken from a prescaler that runs freely from reset. Code 0 ticks every cycle.
- R3: Source codes 10, 11 and 12 tick once every 1024, 8192 and 65536 cycles. Any write to address 12 restarts this coarse divider, and the first coarse tick after that write lands exactly one full period later.
- R4: Source codes 13, 14 and 15 select external pins 0, 1 and 2. Each pin passes through two synchronising flops. A low-to-high change then gives exactly one tick, seen by the timer three clock edges after the pin changes.
- R5: On a tick while enabled, a count above 1 decrements by 1. A count of 1 or 0 instead loads the reload value and pulses that timer's interrupt bit for exactly one cycle, so the interrupt period equals the reload value in ticks.
- R6: A write to address 0 sets the enable register, with bit i enabling timer i. A disabled timer never raises an interrupt.
- R7: A write to address 6+i sets the reload value of 8-bit timer i. If the timer is disabled, the write also loads its count. If it is enabled, the new value first takes effect at its next reload.
- R8: A write to address 11 sets reload bits 11:8 of timer 4 from data bits 3:0 and never changes the live count. A high nibble written after the low byte therefore takes effect only at the next reload.
- R9: A write to address 10 sets reload bits 7:0 of timer 4. If timer 4 is disabled, the same write loads the whole 12-bit reload value into its count.
- R10: A read strobe returns data one cycle later. Address 10 returns count bits 7:0 and address 11 returns count bits 11:8 in bits 3:0, both only while timer 4 is disabled. Reads while it is enabled, and reads of any other address, return 0.
- R11: A disabled timer holds its count unchanged, except when a reload write loads it.
- R12: A write to address 1+i sets the 4-bit source code of timer i from data bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| ext_pin | input | 3 | Asynchronous external count inputs |
| rd_data | output | 8 | Registered read data |
| irq_o | output | 5 | One-cycle interrupt pulse per timer |

## Verification
The bound checker watches several rules on every cycle:
- an interrupt appears only from an enabled timer, and its count then equals the reload value it held before;
- a stopped timer keeps its count while no write occurs;
- a high-nibble write never disturbs a stopped count;
- a low-byte read returns the count from the cycle of the strobe.

Other behaviour can only be shown by the bench's scenarios, where the reference model follows every timer cycle by cycle:
- the exact tick spacing of each prescaler tap, and the restart of the coarse divider;
- pin synchronisation latency;
- reload ordering between the low byte and the high nibble;
- the default source codes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SRC_W     = 4;
  localparam int BYTE_W    = 8;
  localparam int FINE_TAPS = 10;
  localparam int NUM_COARSE = 3;
  localparam int NUM_EXT   = 3;
  localparam int COARSE_W  = 16;
  localparam int PSC_TAPS  = FINE_TAPS + NUM_COARSE;
  localparam logic [SRC_W-1:0] SRC_RST_NARROW = 4'd2;
  localparam logic [SRC_W-1:0] SRC_RST_WIDE   = 4'd9;

  // counter bits that must all be ones for coarse tap k (1024, 8192, 65536)
  function automatic int coarse_bits(input int k);
    case (k)
      0:       return 10;
      1:       return 13;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  output logic [PSC_TAPS-1:0] tap_o
);
  localparam int FINE_W = FINE_TAPS - 1;

  logic [FINE_W-1:0]   fine_q;
  logic [COARSE_W-1:0] coarse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fine_q   <= '0;
      coarse_q <= '0;
    end else begin
      fine_q   <= fine_q + 1'b1;
      coarse_q <= clr_i ? '0 : coarse_q + 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < FINE_TAPS; g++) begin : g_fine
      if (g == 0) begin : g_div1
        assign tap_o[g] = 1'b1;
      end else begin : g_divn
        assign tap_o[g] = &fine_q[g-1:0];
      end
    end
    for (g = 0; g < NUM_COARSE; g++) begin : g_coarse
      assign tap_o[FINE_TAPS+g] = &coarse_q[coarse_bits(g)-1:0];
    end
  endgenerate
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W  = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic [BW-1:0] wdata_i,
  output logic [W-1:0]  cnt_o,
  output logic [W-1:0]  rld_o,
  output logic          irq_o
);
  logic [W-1:0] cnt_q, rld_q, rld_nx;
  logic         irq_q;

  generate
    if (W > BW) begin : g_split
      always_comb begin
        rld_nx = rld_q;
        if (ld_lo_i) rld_nx[BW-1:0] = wdata_i;
        if (ld_hi_i) rld_nx[W-1:BW] = wdata_i[W-BW-1:0];
      end
    end else begin : g_flat
      logic unused_hi;
      assign unused_hi = ld_hi_i;
      always_comb begin
        rld_nx = rld_q;
        if (ld_lo_i) rld_nx = wdata_i[W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      rld_q <= rld_nx;
      if (!en_i && ld_lo_i) begin
        cnt_q <= rld_nx;
      end else if (en_i && tick_i) begin
        if (cnt_q <= W'(1)) begin
          cnt_q <= rld_q;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_array.sv
module tmr_array
  import tmr_pkg::*;
#(
  parameter int NUM_NARROW = 4,
  parameter int NARROW_W   = 8,
  parameter int WIDE_W     = 12,
  parameter int ADDR_W     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [NUM_EXT-1:0]  ext_pin,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [NUM_NARROW:0] irq_o
);
  localparam int NUM_TMR  = NUM_NARROW + 1;
  localparam int WIDE_IDX = NUM_NARROW;
  localparam int NUM_TAPS = 1 << SRC_W;
  localparam int A_EN     = 0;
  localparam int A_SRC    = 1;
  localparam int A_RLD    = A_SRC + NUM_TMR;
  localparam int A_WLO    = A_RLD + NUM_NARROW;
  localparam int A_WHI    = A_WLO + 1;
  localparam int A_PCLR   = A_WHI + 1;

  logic [NUM_TMR-1:0]        en_q;
  logic [SRC_W-1:0]          src_q [NUM_TMR];
  logic [PSC_TAPS-1:0]       psc_tap;
  logic [NUM_EXT-1:0]        ext_rise;
  logic [NUM_TAPS-1:0]       tap_all;
  logic [NUM_TMR-1:0]        tick;
  logic [WIDE_W-1:0]         cnt_w;
  logic [NUM_TMR*WIDE_W-1:0] cnt_obs_unused;
  logic [NUM_TMR*WIDE_W-1:0] rld_obs_unused;
  logic                      psc_clr;

  assign psc_clr = wr_en && (addr == ADDR_W'(A_PCLR));

  tmr_prescale u_psc (
    .clk   (clk),
    .rst   (rst),
    .clr_i (psc_clr),
    .tap_o (psc_tap)
  );

  tmr_pin_sync #(.N(NUM_EXT)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (ext_pin),
    .rise_o (ext_rise)
  );

  assign tap_all = {ext_rise, psc_tap};

  // enable and source-select registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      for (int i = 0; i < NUM_TMR; i++)
        src_q[i] <= (i == WIDE_IDX) ? SRC_RST_WIDE : SRC_RST_NARROW;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_EN)) en_q <= wr_data[NUM_TMR-1:0];
      for (int i = 0; i < NUM_TMR; i++)
        if (addr == ADDR_W'(A_SRC + i)) src_q[i] <= wr_data[SRC_W-1:0];
    end
  end

  genvar t;
  generate
    for (t = 0; t < NUM_TMR; t++) begin : g_tmr
      assign tick[t] = tap_all[src_q[t]];
      if (t == WIDE_IDX) begin : g_wide
        logic [WIDE_W-1:0] cnt, rld;
        tmr_chan #(.W(WIDE_W), .BW(BYTE_W)) u_chan (
          .clk     (clk),
          .rst     (rst),
          .en_i    (en_q[t]),
          .tick_i  (tick[t]),
          .ld_lo_i (wr_en && (addr == ADDR_W'(A_WLO))),
          .ld_hi_i (wr_en && (addr == ADDR_W'(A_WHI))),
          .wdata_i (wr_data),
          .cnt_o   (cnt),
          .rld_o   (rld),
          .irq_o   (irq_o[t])
        );
        assign cnt_w = cnt;
        assign cnt_obs_unused[t*WIDE_W +: WIDE_W] = cnt;
        assign rld_obs_unused[t*WIDE_W +: WIDE_W] = rld;
      end else begin : g_narrow
        logic [NARROW_W-1:0] cnt, rld;
        tmr_chan #(.W(NARROW_W), .BW(BYTE_W)) u_chan (
          .clk     (clk),
          .rst     (rst),
          .en_i    (en_q[t]),
          .tick_i  (tick[t]),
          .ld_lo_i (wr_en && (addr == ADDR_W'(A_RLD + t))),
          .ld_hi_i (1'b0),
          .wdata_i (wr_data),
          .cnt_o   (cnt),
          .rld_o   (rld),
          .irq_o   (irq_o[t])
        );
        assign cnt_obs_unused[t*WIDE_W +: WIDE_W] = WIDE_W'(cnt);
        assign rld_obs_unused[t*WIDE_W +: WIDE_W] = WIDE_W'(rld);
      end
    end
  endgenerate

  // registered readback of the wide counter while it is stopped
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (rd_en && !en_q[WIDE_IDX]) begin
        if (addr == ADDR_W'(A_WLO))
          rd_data <= cnt_w[BYTE_W-1:0];
        else if (addr == ADDR_W'(A_WHI))
          rd_data <= BYTE_W'(cnt_w[WIDE_W-1:BYTE_W]);
      end
    end
  end
endmodule

// File: rtl/tmr_array_chk.sv
module tmr_array_chk #(
  parameter int NUM    = 5,
  parameter int CW     = 12,
  parameter int ADDR_W = 4,
  parameter int A_WLO  = 10,
  parameter int A_WHI  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM-1:0]    en_q,
  input logic [NUM-1:0]    irq_o,
  input logic [NUM*CW-1:0] cnt_obs_unused,
  input logic [NUM*CW-1:0] rld_obs_unused,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rd_data
);
  localparam int WI = NUM - 1;

  genvar i;
  generate
    for (i = 0; i < NUM; i++) begin : g_a
      // R6: interrupts only from an enabled timer
      a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_o[i] |-> $past(en_q[i]));
      // R5: the interrupt cycle shows the reloaded value
      a_r5_irq_reloads: assert property (@(posedge clk) disable iff (rst)
        irq_o[i] |-> cnt_obs_unused[i*CW +: CW] == $past(rld_obs_unused[i*CW +: CW]));
      // R11: a stopped timer keeps its count without writes
      a_r11_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!$past(en_q[i]) && !$past(wr_en)) |-> $stable(cnt_obs_unused[i*CW +: CW]));
    end
  endgenerate

  // R10: low-byte readback of a stopped wide timer
  a_r10_readback_lo: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(A_WLO) && !en_q[WI]) |=>
      rd_data == $past(cnt_obs_unused[WI*CW +: 8]));
  // R8: a high-nibble write leaves a stopped count untouched
  a_r8_hi_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_WHI) && !en_q[WI]) |=>
      $stable(cnt_obs_unused[WI*CW +: CW]));
endmodule

bind tmr_array tmr_array_chk #(
  .NUM(NUM_TMR), .CW(WIDE_W), .ADDR_W(ADDR_W), .A_WLO(A_WLO), .A_WHI(A_WHI)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .en_q           (en_q),
  .irq_o          (irq_o),
  .cnt_obs_unused (cnt_obs_unused),
  .rld_obs_unused (rld_obs_unused),
  .wr_en          (wr_en),
  .rd_en          (rd_en),
  .addr           (addr),
  .rd_data        (rd_data)
);

// File: tb/tmr_array_bench.sv
`timescale 1ns/1ps
module tmr_array_bench;
  localparam int NT = 5;
  localparam int WI = 4;
  localparam int A_EN = 0, A_SRC = 1, A_RLD = 6, A_WLO = 10, A_WHI = 11, A_PCLR = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] ext_pin = '0;
  logic [7:0] rd_data;
  logic [4:0] irq_o;

  always #4 clk = ~clk;

  tmr_array u_tmr_array (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .ext_pin(ext_pin), .rd_data(rd_data), .irq_o(irq_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int  m_fine, m_coarse;
  int  m_cnt [NT], m_rld [NT], m_src [NT];
  bit  m_en [NT];
  bit  m_s1 [3], m_s2 [3], m_s3 [3];
  logic [4:0] exp_irq;
  logic [7:0] exp_rd;

  function automatic bit tap(int code);
    if (code < 10) return (m_fine % (1 << code)) == (1 << code) - 1;
    if (code == 10) return (m_coarse % 1024) == 1023;
    if (code == 11) return (m_coarse % 8192) == 8191;
    if (code == 12) return m_coarse == 65535;
    return m_s2[code-13] && !m_s3[code-13];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_fine = 0; m_coarse = 0; exp_irq = '0; exp_rd = '0;
      for (int i = 0; i < NT; i++) begin
        m_cnt[i] = 0; m_rld[i] = 0; m_en[i] = 0; m_src[i] = (i == WI) ? 9 : 2;
      end
      for (int j = 0; j < 3; j++) begin m_s1[j] = 0; m_s2[j] = 0; m_s3[j] = 0; end
    end else begin
      int a, d;
      bit tk [NT];
      a = int'(addr); d = int'(wr_data);
      for (int i = 0; i < NT; i++) tk[i] = m_en[i] && tap(m_src[i]);
      exp_rd = '0;
      if (rd_en && !m_en[WI]) begin
        if (a == A_WLO) exp_rd = 8'(m_cnt[WI] & 255);
        else if (a == A_WHI) exp_rd = 8'(m_cnt[WI] >> 8);
      end
      exp_irq = '0;
      for (int i = 0; i < NT; i++) begin
        bit lo, hi;
        int nr;
        lo = wr_en && (a == ((i == WI) ? A_WLO : A_RLD + i));
        hi = wr_en && (i == WI) && (a == A_WHI);
        nr = m_rld[i];
        if (lo) nr = (i == WI) ? ((nr & 'hF00) | d) : d;
        if (hi) nr = (nr & 255) | ((d & 15) << 8);
        if (!m_en[i] && lo) m_cnt[i] = nr;
        else if (tk[i]) begin
          if (m_cnt[i] <= 1) begin m_cnt[i] = m_rld[i]; exp_irq[i] = 1'b1; end
          else m_cnt[i] = m_cnt[i] - 1;
        end
        m_rld[i] = nr;
      end
      if (wr_en && a == A_EN) for (int i = 0; i < NT; i++) m_en[i] = wr_data[i];
      for (int i = 0; i < NT; i++) if (wr_en && a == A_SRC + i) m_src[i] = d & 15;
      m_fine = (m_fine + 1) % 512;
      m_coarse = (wr_en && a == A_PCLR) ? 0 : (m_coarse + 1) % 65536;
      for (int j = 0; j < 3; j++) begin m_s3[j] = m_s2[j]; m_s2[j] = m_s1[j]; m_s1[j] = ext_pin[j]; end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (irq_o !== exp_irq) begin
        n_bad++;
        $display("FAIL R5 irq_o actual=%b expected=%b at %0t", irq_o, exp_irq, $time);
      end
      n_chk++;
      if (rd_data !== exp_rd) begin
        n_bad++;
        $display("FAIL R10 rd_data actual=%h expected=%h at %0t", rd_data, exp_rd, $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_en = 1'b1; addr = 4'(a);
    @(negedge clk); rd_en = 1'b0; v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq after reset", int'(irq_o), 0);
    rd(A_WLO, v); chk("R1 wide low after reset", v, 0);
    rd(A_WHI, v); chk("R1 wide high after reset", v, 0);
    // R9: stopped wide timer, low byte loads the whole value
    wr(A_WHI, 3); wr(A_WLO, 'h21);
    rd(A_WLO, v); chk("R9 low byte", v, 'h21);
    rd(A_WHI, v); chk("R9 high nibble", v, 3);
    // R8: high nibble alone leaves the count
    wr(A_WHI, 5);
    rd(A_WHI, v); chk("R8 count high unchanged", v, 3);
    // R11: stopped count holds
    idle(20);
    rd(A_WLO, v); chk("R11 hold low", v, 'h21);
    // R12 + R2: timer0 at divide-by-1, reload 3
    wr(A_SRC + 0, 0); wr(A_RLD + 0, 3);
    // R7: timer1 keeps default source 2 (R1), reload 5
    wr(A_RLD + 1, 5);
    // R3: timer2 on the 1024 tap, reload 2
    wr(A_SRC + 2, 10); wr(A_RLD + 2, 2);
    // R4: timer3 on external pin 0, reload 2
    wr(A_SRC + 3, 13); wr(A_RLD + 3, 2);
    wr(A_EN, 'h0F); // R6
    idle(40);
    wr(A_RLD + 0, 6); // R7: takes effect at the next reload
    idle(40);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); ext_pin = 3'b001; idle(5);
      @(negedge clk); ext_pin = 3'b010; idle(5); // pin 1 is not selected
      @(negedge clk); ext_pin = 3'b000; idle(5);
    end
    idle(1500);
    wr(A_PCLR, 0); // R3: restart coarse divider
    idle(700);
    wr(A_PCLR, 0);
    idle(3000);
    // R2: timer1 on divide-by-512
    wr(A_SRC + 1, 9);
    idle(1200);
    // wide timer: divide-by-4, enable all
    wr(A_SRC + WI, 2); wr(A_WHI, 0); wr(A_WLO, 'h30);
    wr(A_EN, 'h1F);
    rd(A_WLO, v); chk("R10 read while enabled", v, 0);
    idle(600);
    // R8: low byte first, then high nibble while running
    wr(A_WLO, 'h10); wr(A_WHI, 1);
    idle(2500);
    // R6: everything stopped, no interrupts
    wr(A_EN, 0);
    idle(200);
    chk("R6 no irq when disabled", int'(irq_o), 0);
    rd(A_WHI, v); rd(A_WLO, v);
    idle(5);
    finish_run();
  end
endmodule